// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full-width product of two N-bit unsigned numbers with a single N-bit adder that is used once per cycle over N cycles. A one-cycle start request captures the two operands. The block then works through the multiplier one bit per cycle, lowest bit first. Each bit decides whether the multiplicand is added into an accumulator. The adder's carry-out, the accumulator and the multiplier register then move right one place together. Product bits that leave the accumulator fill the multiplier register from the top, so after N steps the accumulator holds the upper half of the result and the multiplier register holds the lower half.

A done flag marks the cycle in which the result becomes valid. The result stays on the output until the next accepted start. A start that arrives during a multiplication has no effect. A start that arrives in the done cycle begins the next multiplication straight away.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and directly after it, busy and done are 0 and product is all zeros.
- R2: A start sampled high while not busy loads both operands and clears the accumulator and carry. busy reads 1 from the next cycle.
- R3: The 2N-bit product equals mcand times mplier as unsigned integers. For N=4, 13 times 11 gives 143.
- R4: done is high for exactly one cycle. That cycle starts on the Nth rising edge after the edge that sampled start. busy is high for the N cycles in between.
- R5: A start sampled while busy is ignored. Both the result and the timing of the running multiplication are unchanged.
- R6: After done, product and done do not change until the next accepted start.
- R7: A start sampled during the done cycle begins a new multiplication with the new operands, with the same latency as in R4.
- R8: Full-scale operands give the correct product. The adder's carry-out reaches the product through the shift (for N=8, 255 times 255 gives 65025).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | N | Multiplicand, sampled with start |
| mplier | input | N | Multiplier, sampled with start |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle result-valid flag |
| product | output | 2N | Result: accumulator as upper half, multiplier register as lower half |

## Verification
The assertions assume that the operands are only meaningful in a cycle where start is high and busy is low. They also assume that start is a level sampled on the rising edge, with no handshake, and that reset is applied once before any request. The stimulus follows these assumptions. It changes start and the operands only on the falling edge, holds each request for one full cycle, and releases reset before the first request. Deliberate starts during a busy period exercise the ignore path with operands different from the running ones, so a wrong capture shows up in the product.

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t        state;
  logic [N-1:0]  m_q, a_q, q_q;
  logic          c_q;
  logic [CW-1:0] cnt_q;
  logic [N:0]    sum;
  logic          accept;

  assign accept  = start && (state != S_RUN);
  assign sum     = q_q[0] ? ({1'b0, a_q} + {1'b0, m_q}) : {c_q, a_q};
  assign busy    = (state == S_RUN);
  assign done    = (state == S_DONE);
  assign product = {a_q, q_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      m_q   <= '0;
      a_q   <= '0;
      q_q   <= '0;
      c_q   <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      state <= S_RUN;
      m_q   <= mcand;
      q_q   <= mplier;
      a_q   <= '0;
      c_q   <= 1'b0;
      cnt_q <= '0;
    end else if (state == S_RUN) begin
      c_q   <= 1'b0;
      a_q   <= sum[N:1];
      q_q   <= {sum[0], q_q[N-1:1]};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(N - 1)) state <= S_DONE;
    end else if (state == S_DONE) begin
      state <= S_IDLE;
    end
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && a_q == '0 && q_q == $past(mplier) && m_q == $past(mcand))); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R4

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(m_q)); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R6

  AST_RESTART_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy); // R7
endmodule

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  shift_add_mul #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {8'd13,  8'd11}, {8'd0,   8'd0},   {8'd1,   8'd1},   {8'd0,   8'd255},
    {8'd255, 8'd0},  {8'd170, 8'd85},  {8'd85,  8'd170}, {8'd128, 8'd2},
    {8'd2,   8'd128},{8'd200, 8'd199}, {8'd17,  8'd240}, {8'd255, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where done is seen.
  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                         input bit poke_busy, output int lat);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      if (poke_busy && lat == 3) begin
        mcand = ~a; mplier = ~b; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    logic [2*N-1:0] held;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && product == 0, "R1 reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && product == 0, "R1 after reset", product, 0);

    for (int i = 0; i < NV; i++) begin
      run_mul(VEC[i][15:8], VEC[i][7:0], 1'b0, lat);
      chk(product == VEC[i][15:8] * VEC[i][7:0], "R3 product", product,
          VEC[i][15:8] * VEC[i][7:0]);
      chk(lat == N, "R4 latency", lat, N);
      @(negedge clk);
      chk(done == 0, "R4 done one cycle", done, 0);
    end

    // R2: busy follows start
    mcand = 8'd9; mplier = 8'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1 && product[2*N-1:N] == 0 && product[N-1:0] == 7, "R2 load", product, 7);
    while (!done) @(negedge clk);
    chk(product == 63, "R2 result", product, 63);

    // R8: full scale
    @(negedge clk);
    run_mul(8'd255, 8'd255, 1'b0, lat);
    chk(product == 65025, "R8 full scale", product, 65025);

    // R5: start during busy ignored
    @(negedge clk);
    run_mul(8'd37, 8'd91, 1'b1, lat);
    chk(product == 37 * 91, "R5 ignore start", product, 37 * 91);
    chk(lat == N, "R5 latency", lat, N);

    // R7: restart in done cycle
    run_mul(8'd250, 8'd3, 1'b0, lat);
    chk(product == 750, "R7 restart product", product, 750);
    chk(lat == N, "R7 restart latency", lat, N);

    // R6: result holds
    held = product;
    mcand = 8'd1; mplier = 8'd1;
    repeat (6) @(negedge clk);
    chk(product == held && done == 0 && busy == 0, "R6 hold", product, held);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule